// File: doc/BRIEF.md
# DRAM Refresh Request Accumulator

This block keeps the number of DRAM refreshes that a memory controller owes. A programmable interval timer produces one tick per refresh interval, and each tick adds one to a saturating owed-refresh counter. While refresh issue is enabled and DRAM initialization is complete, a nonzero count raises a refresh request toward the command scheduler. Each refresh acknowledge from the scheduler takes one off the count.

Two enables set the accrual and issue behaviour. The refresh enable turns on both accrual and issue. The accrual enable lets owed refreshes build up while issue stays off, for example while the DIMMs are being set up again. Accrual stops while DRAM is in self-refresh. When self-refresh ends, a 2-bit top-up setting adds 0 to 3 extra refreshes to the count. The register that drives this setting is expected to reset to code 2'b10, which adds two refreshes.

Top module: `refresh_owed_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, `owed_count` becomes 0 and `refresh_req` is 0. The interval timer loads `interval_ticks` during reset.
- R2: While accrual is active, the timer gives one tick every `interval_ticks`+1 clock cycles of accrual. The first tick comes on the (`interval_ticks`+1)-th active cycle after reset, and each tick adds one to `owed_count` at that clock edge.
- R3: With `refresh_en`=0 and `accrue_en`=0, `owed_count` never grows from ticks.
- R4: With `refresh_en`=0 and `accrue_en`=1, `owed_count` grows from ticks and `refresh_req` stays 0.
- R5: With `refresh_en`=1, `owed_count` grows from ticks whatever the value of `accrue_en`. `refresh_req` is 1 exactly when `init_done`=1 and `owed_count` is nonzero.
- R6: With `init_done`=0, `refresh_req` stays 0 even when refreshes are owed.
- R7: While `selfref_active`=1, no ticks occur, the timer holds its phase, and `owed_count` does not grow from ticks.
- R8: The clock edge that first samples `selfref_active` low after it was high adds a top-up to `owed_count` exactly once, whatever the enables are. The `topup_code` values are 2'b00 for 0, 2'b01 for 1, 2'b10 for 2 and 2'b11 for 3.
- R9: Each cycle with `refresh_ack`=1 takes one off `owed_count`. The count never goes below 0.
- R10: `owed_count` saturates at 2^CNT_W-1, which is 15 by default, and never wraps.
- R11: A top-up, a tick and an acknowledge in the same cycle combine into one net update: count + top-up + tick - ack, clamped to the range 0 to 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_en | input | 1 | Enables refresh issue and accrual |
| accrue_en | input | 1 | Enables accrual while refresh issue is off |
| init_done | input | 1 | DRAM initialization complete |
| topup_code | input | 2 | Extra refreshes added on self-refresh exit |
| interval_ticks | input | INT_W (16) | Timer reload value; period is this value plus one |
| selfref_active | input | 1 | DRAM is in self-refresh |
| refresh_ack | input | 1 | Scheduler issued one refresh this cycle |
| refresh_req | output | 1 | Refreshes are owed and may be issued |
| owed_count | output | CNT_W (4) | Number of owed refreshes |

## Verification
Accrual is tested in all three enable combinations. The bench counts the clock edges exactly, so the tests tell the off state apart from accrual-only and from full issue, and they show whether the request is gated by the refresh enable or by initialization. Self-refresh is tested with the enables off, which isolates the top-up: each code is applied in turn, and a second low cycle shows the top-up is applied only once. A long self-refresh stay followed by a counted resume shows that the timer phase is held. A one-cycle interval drives the counter into saturation. A single exit cycle that carries a top-up, a tick and an acknowledge at once separates the net update from an ordered or partial one.

// File: rtl/refq_pkg.sv
// Shared types for the refresh accumulator.
// Assumes: top-up codes are two bits wide and map directly to amounts 0 to 3.
package refq_pkg;

    typedef enum logic [1:0] {
        TOPUP_NONE  = 2'b00,
        TOPUP_ONE   = 2'b01,
        TOPUP_TWO   = 2'b10,
        TOPUP_THREE = 2'b11
    } topup_e;

    // Converts a top-up code to the number of refreshes to add.
    function automatic logic [2:0] topup_amount(input topup_e code);
        case (code)
            TOPUP_NONE:  topup_amount = 3'd0;
            TOPUP_ONE:   topup_amount = 3'd1;
            TOPUP_TWO:   topup_amount = 3'd2;
            default:     topup_amount = 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/refq_interval_timer.sv
// Down-counting interval timer. While run is high it counts toward zero.
// At zero it emits one tick and reloads. While run is low it holds its phase.
// Assumes: reload_val is stable across reset release; period = reload_val + 1.
module refq_interval_timer #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [INT_W-1:0] reload_val,
    output logic             tick
);

    logic [INT_W-1:0] remain;

    // Tick fires in the active cycle in which the timer reads zero.
    always_comb tick = run && (remain == '0);

    // Count down while running, reload on expiry, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= reload_val;
        end else if (run) begin
            if (remain == '0) remain <= reload_val;
            else              remain <= remain - INT_W'(1);
        end
    end

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(remain)); // R7

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> remain == $past(reload_val)); // R2

endmodule

// File: rtl/refq_sr_exit_detect.sv
// Flags the cycle in which the self-refresh status first drops after being high.
// Assumes: sr_active is already synchronous to clk.
module refq_sr_exit_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_active,
    output logic sr_exit
);

    logic sr_q;

    // Remember last cycle's self-refresh status.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= 1'b0;
        else        sr_q <= sr_active;
    end

    // Exit is the high-to-low transition seen this cycle.
    always_comb sr_exit = sr_q && !sr_active;

    AST_EXIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> !sr_exit); // R8

endmodule

// File: rtl/refq_owed_counter.sv
// Saturating owed-refresh counter. Each cycle it applies a single net update:
// top-up plus tick minus acknowledge, clamped between zero and full scale.
// Assumes: topup is already zero except in the self-refresh exit cycle.
module refq_owed_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       topup,
    input  logic             tick,
    input  logic             ack,
    output logic [CNT_W-1:0] count
);

    localparam int SUM_W = CNT_W + 3;
    localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << CNT_W) - 1);

    logic [SUM_W-1:0] gross;
    logic [SUM_W-1:0] net;

    // Combine all additions, take off an acknowledge with a floor of zero, then clamp.
    always_comb begin
        gross = SUM_W'(count) + SUM_W'(topup) + SUM_W'(tick);
        if (ack && gross != '0) net = gross - SUM_W'(1);
        else                    net = gross;
        if (net > FULL) net = FULL;
    end

    // Register the clamped net result.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= net[CNT_W-1:0];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {CNT_W{1'b1}} && !ack) |=> count == {CNT_W{1'b1}}); // R10

    AST_ACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick && topup == 3'd0 && count != '0) |=> count == $past(count) - CNT_W'(1)); // R9

    AST_ACK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick && topup == 3'd0 && count == '0) |=> count == '0); // R9

endmodule

// File: rtl/refresh_owed_tracker.sv
// Top level of the refresh accumulator. It decides when accrual runs, detects
// self-refresh exit, applies the top-up and raises the refresh request.
// Assumes: all inputs are synchronous to clk; refresh_ack only follows refresh_req.
module refresh_owed_tracker
    import refq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_en,
    input  logic             accrue_en,
    input  logic             init_done,
    input  logic [1:0]       topup_code,
    input  logic [INT_W-1:0] interval_ticks,
    input  logic             selfref_active,
    input  logic             refresh_ack,
    output logic             refresh_req,
    output logic [CNT_W-1:0] owed_count
);

    logic       accrue_run;
    logic       tick;
    logic       sr_exit;
    logic [2:0] topup_now;

    // Accrual runs under either enable, but only outside self-refresh.
    always_comb accrue_run = (refresh_en || accrue_en) && !selfref_active;

    // Top-up amount applies only in the exit cycle.
    always_comb topup_now = sr_exit ? topup_amount(topup_e'(topup_code)) : 3'd0;

    refq_interval_timer #(.INT_W(INT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (accrue_run),
        .reload_val (interval_ticks),
        .tick       (tick)
    );

    refq_sr_exit_detect u_exit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_active (selfref_active),
        .sr_exit   (sr_exit)
    );

    refq_owed_counter #(.CNT_W(CNT_W)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .topup (topup_now),
        .tick  (tick),
        .ack   (refresh_ack),
        .count (owed_count)
    );

    // Request issue while enabled, initialized and owing.
    always_comb refresh_req = refresh_en && init_done && (owed_count != '0);

    AST_REQ_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_count == '0) |-> !refresh_req); // R5

    AST_REQ_OFF_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_en || !init_done) |-> !refresh_req); // R6

    AST_NO_GROW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_en && !accrue_en && !sr_exit) |=> owed_count <= $past(owed_count)); // R3

endmodule

// File: tb/refresh_owed_tracker_bench.sv
module refresh_owed_tracker_bench;

    localparam int CW = 4;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_en = 1'b0;
    logic          accrue_en = 1'b0;
    logic          init_done = 1'b0;
    logic [1:0]    topup_code = 2'b10;
    logic [IW-1:0] interval_ticks = 16'd3;
    logic          selfref_active = 1'b0;
    logic          refresh_ack = 1'b0;
    logic          refresh_req;
    logic [CW-1:0] owed_count;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    refresh_owed_tracker #(.CNT_W(CW), .INT_W(IW)) u_refresh_owed_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .refresh_en     (refresh_en),
        .accrue_en      (accrue_en),
        .init_done      (init_done),
        .topup_code     (topup_code),
        .interval_ticks (interval_ticks),
        .selfref_active (selfref_active),
        .refresh_ack    (refresh_ack),
        .refresh_req    (refresh_req),
        .owed_count     (owed_count)
    );

    task automatic chk(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Reset with the given interval and check the reset state (R1).
    task automatic do_reset(input logic [IW-1:0] ival);
        @(negedge clk);
        rst_n = 1'b0;
        interval_ticks = ival;
        refresh_ack = 1'b0;
        step(2);
        chk("R1 count in reset", owed_count, 0);
        chk("R1 req in reset", refresh_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_off();
        refresh_en = 0; accrue_en = 0; init_done = 1; selfref_active = 0;
        do_reset(16'd3);
        step(20);
        chk("R3 no accrual when off", owed_count, 0);
    endtask

    task automatic t_accrue_only();
        refresh_en = 1; accrue_en = 1; init_done = 1; selfref_active = 0;
        do_reset(16'd3);
        refresh_en = 0;
        step(3);
        chk("R2 no tick before period", owed_count, 0);
        step(1);
        chk("R2 first tick at period", owed_count, 1);
        step(8);
        chk("R4 accrual with issue off", owed_count, 3);
        chk("R4 no request", refresh_req, 0);
    endtask

    task automatic t_issue();
        refresh_en = 1; accrue_en = 0; init_done = 0; selfref_active = 0;
        do_reset(16'd3);
        step(8);
        chk("R5 accrual ignores accrue_en", owed_count, 2);
        chk("R6 no request before init", refresh_req, 0);
        init_done = 1;
        #1;
        chk("R5 request when owed", refresh_req, 1);
    endtask

    task automatic t_ack();
        refresh_en = 1; accrue_en = 0; init_done = 1; selfref_active = 0;
        do_reset(16'd3);
        step(8);
        chk("R9 setup", owed_count, 2);
        @(negedge clk); refresh_ack = 1;
        step(1);
        chk("R9 first ack", owed_count, 1);
        step(1);
        chk("R9 second ack", owed_count, 0);
        chk("R5 request drops at zero", refresh_req, 0);
        step(1);
        chk("R9 floor at zero", owed_count, 0);
        refresh_ack = 0;
    endtask

    task automatic t_selfref_hold();
        refresh_en = 0; accrue_en = 1; init_done = 1; selfref_active = 1; topup_code = 2'b00;
        do_reset(16'd3);
        step(20);
        chk("R7 no accrual in self-refresh", owed_count, 0);
        selfref_active = 0;
        step(3);
        chk("R7 phase held, no tick yet", owed_count, 0);
        step(1);
        chk("R7 tick after held phase", owed_count, 1);
    endtask

    task automatic t_topup();
        refresh_en = 0; accrue_en = 0; init_done = 1; selfref_active = 1; topup_code = 2'b10;
        do_reset(16'd3);
        step(2);
        selfref_active = 0;
        step(1);
        chk("R8 code 10 adds 2", owed_count, 2);
        step(2);
        chk("R8 applied once", owed_count, 2);
        selfref_active = 1; topup_code = 2'b11;
        step(2);
        selfref_active = 0;
        step(1);
        chk("R8 code 11 adds 3", owed_count, 5);
        selfref_active = 1; topup_code = 2'b00;
        step(1);
        selfref_active = 0;
        step(1);
        chk("R8 code 00 adds 0", owed_count, 5);
        selfref_active = 1; topup_code = 2'b01;
        step(1);
        selfref_active = 0;
        step(1);
        chk("R8 code 01 adds 1", owed_count, 6);
    endtask

    task automatic t_saturate();
        refresh_en = 0; accrue_en = 1; init_done = 1; selfref_active = 0;
        do_reset(16'd0);
        step(15);
        chk("R10 reaches full", owed_count, 15);
        step(5);
        chk("R10 saturates", owed_count, 15);
        selfref_active = 1; topup_code = 2'b11;
        step(1);
        selfref_active = 0;
        step(1);
        chk("R10 top-up clamps", owed_count, 15);
    endtask

    task automatic t_combined();
        refresh_en = 1; accrue_en = 0; init_done = 1; selfref_active = 1; topup_code = 2'b11;
        do_reset(16'd0);
        step(2);
        chk("R11 setup", owed_count, 0);
        selfref_active = 0; refresh_ack = 1;
        step(1);
        chk("R11 top-up plus tick minus ack", owed_count, 3);
        refresh_ack = 0;
    endtask

    initial begin
        t_off();
        t_accrue_only();
        t_issue();
        t_ack();
        t_selfref_hold();
        t_topup();
        t_saturate();
        t_combined();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule